// File: doc/BRIEF.md
# Vectored Interrupt Controller, 96 Sources

This block collects ninety-six interrupt request lines and drives a single registered interrupt request to a processor. Sources are grouped into banks of 32. Source `n` lives in bank `n/32` at bit `n%32`. Each bank has its own pending, enable and mask word on a simple synchronous register bus. A source reaches the output only when all three of these hold: its pending bit is set, its enable bit is set, and its mask bit is clear. Among the sources that pass, the highest-numbered one wins. Its index, shifted left by two, is presented in a vector word so that the handler can dispatch without scanning.

Sources 1 to 95 are level inputs. Source 0 is an external line that is latched by a small two-state machine, `EXT_IDLE` and `EXT_HELD`, according to a selectable trigger kind.
- The transition `ARM` (`EXT_IDLE` to `EXT_HELD`) fires when the selected trigger condition is seen.
- `KEEP` holds `EXT_HELD` while no clear arrives, or while a clear coincides with a new trigger.
- `RELEASE` (`EXT_HELD` to `EXT_IDLE`) fires on a clear without a trigger.

Because a winning source 0 gives a vector of zero, software tells it apart from "nothing active" by reading bit 0 of pending bank 0. A one-bit protection flag is held for software. It does not gate any access.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads zero and `irq_o` is low.
- R2: Enable words at byte offsets 0x40, 0x44, 0x48 and mask words at 0x50, 0x54, 0x58 (bank b at base + 4*b) hold and read back the full 32-bit value last written.
- R3: For sources 1 to 95, the pending bit read at 0x10/0x14/0x18 equals the source input as sampled at the previous clock edge. Writing to a pending word does not change these bits.
- R4: A source contributes to the vector and to `irq_o` only if it is pending, its enable bit is 1 and its mask bit is 0.
- R5: Reading offset 0x00 returns the index of the highest-numbered contributing source in bits [8:2], with all other bits zero. It reads zero when no source contributes.
- R6: `irq_o` is a register. It is high exactly when at least one source contributed at the preceding clock edge, so a change in enable or mask shows on `irq_o` one cycle after the write.
- R7: The trigger of source 0 is set by bits [1:0] at offset 0x0C (0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge). A qualifying condition at a clock edge sets pending bit 0 of bank 0.
- R8: Pending bit 0 of bank 0 stays set until a write to 0x10 with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set. A trigger in the same cycle as the clear keeps it set.
- R9: Offset 0x08 holds a one-bit protection flag in bit 0, with upper bits reading zero. Its value has no effect on any other register access.
- R10: Offsets not listed above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 96 | Interrupt request lines, source n on bit n |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Several properties are checked by assertions on every cycle:
- the priority encoder's winner is an active source with no active source above it, and it is idle only when nothing passes the gating;
- a non-zero vector always comes with a raised `irq_o`;
- the source-0 state machine holds through `KEEP`, takes `RELEASE` on a lone clear, and takes `ARM` on a rising edge.

Some behaviour is shown only by the bench scenarios:
- the one-cycle latency of `irq_o` after enable and mask writes;
- the read-back values and offsets;
- the level, falling and low trigger kinds;
- writes to pending words leaving level sources untouched;
- the protection flag having no effect.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFS_VECTOR  = 8'h00;
    localparam logic [7:0] OFS_PROTECT = 8'h08;
    localparam logic [7:0] OFS_EXTCTL  = 8'h0C;
    localparam logic [7:0] OFS_PEND    = 8'h10;
    localparam logic [7:0] OFS_ENABLE  = 8'h40;
    localparam logic [7:0] OFS_MASK    = 8'h50;

    typedef enum logic [1:0] {
        EXT_LOW  = 2'd0,
        EXT_HIGH = 2'd1,
        EXT_FALL = 2'd2,
        EXT_RISE = 2'd3
    } ext_mode_e;

    typedef enum logic [0:0] {
        EXT_IDLE = 1'b0,
        EXT_HELD = 1'b1
    } ext_state_e;

endpackage

// File: rtl/vic_ext_latch.sv
module vic_ext_latch
    import vic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      src_i,
    input  ext_mode_e mode_i,
    input  logic      clr_i,
    output logic      pend_o
);

    ext_state_e state_q, state_d;
    logic       prev_q;
    logic       trig;

    // Trigger condition for the selected kind
    always_comb begin
        unique case (mode_i)
            EXT_LOW:  trig = ~src_i;
            EXT_HIGH: trig = src_i;
            EXT_FALL: trig = prev_q & ~src_i;
            EXT_RISE: trig = ~prev_q & src_i;
            default:  trig = 1'b0;
        endcase
    end

    // Next-state: ARM, KEEP, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_IDLE: if (trig)            state_d = EXT_HELD;   // ARM
            EXT_HELD: if (clr_i && !trig)  state_d = EXT_IDLE;   // RELEASE, else KEEP
            default:                       state_d = EXT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXT_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= src_i;
        end
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == EXT_HELD);
    end

    assert_keep_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXT_HELD && !clr_i) |=> (state_q == EXT_HELD));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXT_HELD && clr_i && !trig) |=> (state_q == EXT_IDLE));

    assert_arm_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EXT_RISE && src_i && !prev_q) |=> pend_o);

endmodule

// File: rtl/vic_bank.sv
module vic_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              mk_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pend_i,
    output logic [BANK_W-1:0] en_o,
    output logic [BANK_W-1:0] mk_o,
    output logic [BANK_W-1:0] act_o
);

    logic [BANK_W-1:0] en_q, mk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            mk_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            if (mk_we) mk_q <= wdata;
        end
    end

    always_comb begin
        en_o  = en_q;
        mk_o  = mk_q;
        act_o = pend_i & en_q & ~mk_q;
    end

endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int NUM_SRC = 96,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               valid_o
);

    // Ascending scan: the last active source seen (highest number) wins.
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_i[i]) begin
                idx_o   = IDX_W'(i);
                valid_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_src,
    output logic                        irq_o
);

    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int VEC_LSB = 2;

    logic [NUM_SRC-1:1] lvl_q;
    logic               ext_pend;
    logic [NUM_SRC-1:0] pend_all, en_all, mk_all, act_all;
    logic [IDX_W-1:0]   win_idx, vec_q;
    logic               win_valid, irq_q;
    logic               prot_q;
    ext_mode_e          ext_mode_q;
    logic               pend0_clr;

    // Level sources: one register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= irq_src[NUM_SRC-1:1];
    end

    // Control words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q     <= 1'b0;
            ext_mode_q <= EXT_LOW;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_PROTECT)) prot_q <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFS_EXTCTL))  ext_mode_q <= ext_mode_e'(bus_wdata[1:0]);
        end
    end

    assign pend0_clr = bus_we && (bus_addr == ADDR_W'(OFS_PEND)) && bus_wdata[0];

    vic_ext_latch u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (irq_src[0]),
        .mode_i (ext_mode_q),
        .clr_i  (pend0_clr),
        .pend_o (ext_pend)
    );

    assign pend_all = {lvl_q, ext_pend};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic en_we, mk_we;
        assign en_we = bus_we && (bus_addr == ADDR_W'(OFS_ENABLE + 8'(4 * b)));
        assign mk_we = bus_we && (bus_addr == ADDR_W'(OFS_MASK + 8'(4 * b)));

        vic_bank #(.BANK_W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_we  (en_we),
            .mk_we  (mk_we),
            .wdata  (bus_wdata),
            .pend_i (pend_all[b*BANK_W +: BANK_W]),
            .en_o   (en_all[b*BANK_W +: BANK_W]),
            .mk_o   (mk_all[b*BANK_W +: BANK_W]),
            .act_o  (act_all[b*BANK_W +: BANK_W])
        );
    end

    vic_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
        .act_i   (act_all),
        .idx_o   (win_idx),
        .valid_o (win_valid)
    );

    // Registered request and vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= win_valid;
            vec_q <= win_idx;
        end
    end

    assign irq_o = irq_q;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_VECTOR))
            bus_rdata = BANK_W'({vec_q, {VEC_LSB{1'b0}}});
        else if (bus_addr == ADDR_W'(OFS_PROTECT))
            bus_rdata = BANK_W'(prot_q);
        else if (bus_addr == ADDR_W'(OFS_EXTCTL))
            bus_rdata = BANK_W'(ext_mode_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_PEND + 8'(4 * b)))
                bus_rdata = pend_all[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(OFS_ENABLE + 8'(4 * b)))
                bus_rdata = en_all[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(OFS_MASK + 8'(4 * b)))
                bus_rdata = mk_all[b*BANK_W +: BANK_W];
        end
    end

    assert_winner_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (act_all[win_idx] && ((act_all >> win_idx) == NUM_SRC'(1))));

    assert_idle_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (act_all == '0));

    assert_vector_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q != '0) |-> irq_q);

endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] irq_src = '0;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares away from the edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic check_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk);
        irq_src[i] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        irq_src[0] = 1'b1;            // keep low-level trigger quiet
        wait_cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check_rd(8'h00, 32'h0, "R1 vector");
        check_rd(8'h10, 32'h0, "R1 pend0");
        check_rd(8'h44, 32'h0, "R1 enable1");
        check_rd(8'h58, 32'h0, "R1 mask2");
        check_rd(8'h08, 32'h0, "R1 protect");
        check_rd(8'h0C, 32'h0, "R1 extctl");
        check_irq(1'b0, "R1 irq");

        // R2 read-back
        bus_write(8'h44, 32'hA5A5_0F0F);
        check_rd(8'h44, 32'hA5A5_0F0F, "R2 enable1");
        bus_write(8'h58, 32'h1234_5678);
        check_rd(8'h58, 32'h1234_5678, "R2 mask2");
        bus_write(8'h58, 32'h0);
        bus_write(8'h44, 32'h0);
        check_rd(8'h44, 32'h0, "R2 enable1 cleared");

        // R3 level source 40 (bank 1 bit 8)
        set_src(40, 1'b1);
        wait_cyc(2);
        check_rd(8'h14, 32'h0000_0100, "R3 level pending");
        bus_write(8'h14, 32'hFFFF_FFFF);
        check_rd(8'h14, 32'h0000_0100, "R3 pending write ignored");
        check_irq(1'b0, "R4 not enabled");

        // R4 enabled but masked
        bus_write(8'h54, 32'h0000_0100);
        bus_write(8'h44, 32'h0000_0100);
        wait_cyc(3);
        check_irq(1'b0, "R4 masked");
        check_rd(8'h00, 32'h0, "R4 masked vector");

        // R6 latency after unmask
        bus_write(8'h54, 32'h0);
        check_irq(1'b0, "R6 one cycle latency");
        check_irq(1'b1, "R6 asserted");
        check_rd(8'h00, 32'd160, "R5 vector 40");

        // R5 priority
        set_src(95, 1'b1);
        bus_write(8'h48, 32'h8000_0000);
        wait_cyc(3);
        check_rd(8'h00, 32'd380, "R5 vector 95");
        set_src(5, 1'b1);
        bus_write(8'h40, 32'h0000_0020);
        wait_cyc(3);
        check_rd(8'h00, 32'd380, "R5 95 beats 5");
        set_src(95, 1'b0);
        wait_cyc(3);
        check_rd(8'h00, 32'd160, "R5 back to 40");
        set_src(40, 1'b0);
        wait_cyc(3);
        check_rd(8'h00, 32'd20, "R5 vector 5");
        set_src(5, 1'b0);
        wait_cyc(3);
        check_rd(8'h00, 32'h0, "R5 none active");
        check_irq(1'b0, "R6 deasserted");

        // R7/R8 source 0, rising edge
        bus_write(8'h40, 32'h0000_0001);
        bus_write(8'h0C, 32'h3);
        check_rd(8'h0C, 32'h3, "R7 extctl readback");
        check_rd(8'h10, 32'h0, "R7 no latch on mode change");
        set_src(0, 1'b0); wait_cyc(2);
        check_rd(8'h10, 32'h0, "R7 rising: fall ignored");
        set_src(0, 1'b1); wait_cyc(2);
        check_rd(8'h10, 32'h1, "R7 rising latched");
        check_rd(8'h00, 32'h0, "R5 source0 vector zero");
        check_irq(1'b1, "R5 source0 raises irq");
        set_src(0, 1'b0); wait_cyc(2);
        check_rd(8'h10, 32'h1, "R8 held after input drop");
        bus_write(8'h10, 32'hFFFF_FFFE);
        check_rd(8'h10, 32'h1, "R8 bit0 zero keeps");
        bus_write(8'h10, 32'h1);
        check_rd(8'h10, 32'h0, "R8 cleared");
        wait_cyc(1);
        check_irq(1'b0, "R8 irq after clear");

        // falling edge
        bus_write(8'h0C, 32'h2);
        set_src(0, 1'b1); wait_cyc(2);
        check_rd(8'h10, 32'h0, "R7 falling: rise ignored");
        set_src(0, 1'b0); wait_cyc(2);
        check_rd(8'h10, 32'h1, "R7 falling latched");
        bus_write(8'h10, 32'h1);
        check_rd(8'h10, 32'h0, "R8 clear falling");

        // high level
        bus_write(8'h0C, 32'h1);
        wait_cyc(2);
        check_rd(8'h10, 32'h0, "R7 high: low ignored");
        set_src(0, 1'b1); wait_cyc(2);
        check_rd(8'h10, 32'h1, "R7 high latched");
        bus_write(8'h10, 32'h1);
        check_rd(8'h10, 32'h1, "R8 trigger beats clear");
        set_src(0, 1'b0);
        bus_write(8'h10, 32'h1);
        check_rd(8'h10, 32'h0, "R8 clear after drop");

        // low level
        bus_write(8'h0C, 32'h0);
        wait_cyc(2);
        check_rd(8'h10, 32'h1, "R7 low latched");
        set_src(0, 1'b1);
        bus_write(8'h10, 32'h1);
        check_rd(8'h10, 32'h0, "R8 clear low");

        // R9 protection
        bus_write(8'h08, 32'hFFFF_FFFF);
        check_rd(8'h08, 32'h1, "R9 flag set");
        bus_write(8'h48, 32'hDEAD_BEEF);
        check_rd(8'h48, 32'hDEAD_BEEF, "R9 access unaffected");
        bus_write(8'h08, 32'h0);
        check_rd(8'h08, 32'h0, "R9 flag cleared");

        // R10 unmapped
        bus_write(8'h30, 32'hFFFF_FFFF);
        check_rd(8'h30, 32'h0, "R10 offset 0x30");
        check_rd(8'h04, 32'h0, "R10 offset 0x04");
        check_rd(8'h60, 32'h0, "R10 offset 0x60");

        wait_cyc(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule